// File: doc/BRIEF.md
# Live Memory Increment Migration Engine

This engine empties one memory module of live data so that the module can be pulled out while the system keeps running. It owns the table that maps each absolute storage increment to the physical increment holding its data, plus a bitmap of the physical increments in use. Physical increments are grouped into modules by their upper index bits. When software starts an evacuation of a module, the engine takes the mapped increments on that module one at a time. For each one it reserves a free physical increment on another module and copies the data across.

The copy is cut into sub-increment chunks. Before each chunk the engine asks the system to stop all memory traffic through a request/acknowledge pair. It moves the chunk word by word through a plain read/write memory port, then lets the system run again. It waits a programmable idle gap before the next chunk. The idle gap is clamped to a parameter ceiling, which the integrator sets so that a full module still empties inside the required time budget. The table entry is switched to the new location only after the last chunk. From the moment an evacuation is accepted, new allocations that would land on the departing module are refused.

The increment size, the chunk count per increment and the words per chunk are all parameters. The defaults describe a scaled-down system: 4 modules of 4 increments, 16 absolute increments, 4 chunks of 4 words each.

Top module: `mim_engine`

## Requirements
- R1: A physical increment backs at most one absolute increment. An allocation (alloc_req with alloc_abs, alloc_phys) is accepted, with a one-cycle alloc_ok pulse on the next cycle, only if the absolute increment is unmapped and the physical increment is free. Otherwise alloc_nak pulses on the next cycle. The engine reserves a destination before it copies into it.
- R2: The source is the lowest-numbered mapped absolute increment whose physical increment lies on the target module (module = physical index >> IPM_W). Its destination is the lowest-numbered free physical increment on any other module.
- R3: Each chunk copy waits for pause_ack to be high after pause_req rises. Memory port reads and writes occur only while pause_ack is high. After the last write of a chunk, pause_req drops, and the engine waits for pause_ack to go low before it goes on.
- R4: Each increment is copied as 2^SUB_W chunks of 2^WORD_W words, with 1-cycle read latency. The memory word address is {physical increment, chunk, word}. After the move, the destination holds the source data word for word.
- R5: With pause_ack following pause_req by one clock, pause_req stays low for exactly D+3 cycles between chunks of the same increment, and for D+5 cycles between the last chunk of one increment and the first chunk of the next. D is the effective delay.
- R6: D is min(delay_cfg, DELAY_MAX), with delay_cfg sampled when the start is accepted.
- R7: Lookups of a migrating absolute increment return the source until its last chunk is copied, and the destination afterwards. The source physical increment then becomes free, and a later evacuation may choose it as a destination.
- R8: If a source exists and no destination is free, err rises and stays high, no pause is requested, the mapping is unchanged, and busy drops.
- R9: After a start is accepted, allocations to the target module are refused until the next accepted start. Allocations to other modules are still accepted.
- R10: start is taken only while busy is low. done pulses for one cycle when no mapped increment remains on the target.
- R11: After reset the engine is idle, with no pause request, no error and every lookup invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start evacuation (taken when idle) |
| start_mod | input | MOD_W | Module to evacuate |
| delay_cfg | input | DELAY_W | Requested idle gap between chunks |
| busy | output | 1 | Engine not idle |
| done | output | 1 | One-cycle pulse, evacuation complete |
| err | output | 1 | No destination was available (sticky until next start) |
| pause_req | output | 1 | Request to stop system memory traffic |
| pause_ack | input | 1 | System traffic stopped |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | PHYS_W+SUB_W+WORD_W | Memory read word address |
| mem_rd_data | input | DATA_W | Read data, one cycle after the strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | PHYS_W+SUB_W+WORD_W | Memory write word address |
| mem_wr_data | output | DATA_W | Memory write data |
| alloc_req | input | 1 | New mapping request |
| alloc_abs | input | ABS_W | Absolute increment to map |
| alloc_phys | input | PHYS_W | Physical increment to back it |
| alloc_ok | output | 1 | Mapping accepted (next cycle) |
| alloc_nak | output | 1 | Mapping refused (next cycle) |
| lookup_abs | input | ABS_W | Absolute increment to translate |
| lookup_vld | output | 1 | That increment is mapped |
| lookup_phys | output | PHYS_W | Its physical increment |

## Verification
Assertions check on every cycle that memory traffic happens only under an acknowledged pause, and that a reservation always takes a free increment. They also check that a commit moves between increments that are both held, that allocations to the blocked module are refused, and that an error leaves the pause request low. The bench's scenarios are the only place to see the selection order and the exact idle gaps for each effective delay, including a clamped one. The same goes for the data arriving intact, the source being freed for a later evacuation, the ignored start while busy and the no-destination failure.

// File: rtl/mim_pkg.sv
package mim_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SCAN, ST_PREQ, ST_COPY, ST_REL,
    ST_COMMIT, ST_WAIT, ST_DONE, ST_ERR
  } mim_state_e;
endpackage

// File: rtl/mim_remap_table.sv
module mim_remap_table #(
  parameter int MOD_W = 2,
  parameter int IPM_W = 2,
  parameter int ABS_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blk_en,
  input  logic [MOD_W-1:0]  sel_mod,
  input  logic              alloc_req,
  input  logic [ABS_W-1:0]  alloc_abs,
  input  logic [MOD_W+IPM_W-1:0] alloc_phys,
  output logic              alloc_ok,
  output logic              alloc_nak,
  input  logic              rsv_en,
  input  logic [MOD_W+IPM_W-1:0] rsv_phys,
  input  logic              cmt_en,
  input  logic [ABS_W-1:0]  cmt_abs,
  input  logic [MOD_W+IPM_W-1:0] cmt_src,
  input  logic [MOD_W+IPM_W-1:0] cmt_dst,
  output logic              src_found,
  output logic [ABS_W-1:0]  src_abs,
  output logic [MOD_W+IPM_W-1:0] src_phys,
  output logic              dst_found,
  output logic [MOD_W+IPM_W-1:0] dst_phys,
  input  logic [ABS_W-1:0]  lookup_abs,
  output logic              lookup_vld,
  output logic [MOD_W+IPM_W-1:0] lookup_phys
);
  localparam int PHYS_W   = MOD_W + IPM_W;
  localparam int NUM_PHYS = 1 << PHYS_W;
  localparam int NUM_ABS  = 1 << ABS_W;

  logic [NUM_ABS-1:0]  vld_q, vld_d;
  logic [PHYS_W-1:0]   map_q [NUM_ABS];
  logic [PHYS_W-1:0]   map_d [NUM_ABS];
  logic [NUM_PHYS-1:0] used_q, used_d;
  logic                ok_q, nak_q, accept;

  assign accept = !vld_q[alloc_abs] && !used_q[alloc_phys] && !rsv_en && !cmt_en &&
                  !(blk_en && (alloc_phys[PHYS_W-1:IPM_W] == sel_mod));

  always_comb begin
    vld_d  = vld_q;
    map_d  = map_q;
    used_d = used_q;
    if (alloc_req && accept) begin
      vld_d[alloc_abs]   = 1'b1;
      map_d[alloc_abs]   = alloc_phys;
      used_d[alloc_phys] = 1'b1;
    end
    if (rsv_en) used_d[rsv_phys] = 1'b1;
    if (cmt_en) begin
      map_d[cmt_abs]   = cmt_dst;
      used_d[cmt_src]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      used_q <= '0;
      ok_q   <= 1'b0;
      nak_q  <= 1'b0;
      for (int i = 0; i < NUM_ABS; i++) map_q[i] <= '0;
    end else begin
      vld_q  <= vld_d;
      used_q <= used_d;
      ok_q   <= alloc_req && accept;
      nak_q  <= alloc_req && !accept;
      for (int i = 0; i < NUM_ABS; i++) map_q[i] <= map_d[i];
    end
  end

  // lowest matching entries win: scan downwards, last hit sticks
  always_comb begin
    src_found = 1'b0;
    src_abs   = '0;
    src_phys  = '0;
    for (int i = NUM_ABS - 1; i >= 0; i--) begin
      if (vld_q[i] && (map_q[i][PHYS_W-1:IPM_W] == sel_mod)) begin
        src_found = 1'b1;
        src_abs   = ABS_W'(i);
        src_phys  = map_q[i];
      end
    end
    dst_found = 1'b0;
    dst_phys  = '0;
    for (int p = NUM_PHYS - 1; p >= 0; p--) begin
      if (!used_q[p] && (PHYS_W'(p) >> IPM_W) != PHYS_W'(sel_mod)) begin
        dst_found = 1'b1;
        dst_phys  = PHYS_W'(p);
      end
    end
  end

  assign alloc_ok    = ok_q;
  assign alloc_nak   = nak_q;
  assign lookup_vld  = vld_q[lookup_abs];
  assign lookup_phys = map_q[lookup_abs];

  AST_RSV_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_en |-> !used_q[rsv_phys]); // R1
  AST_CMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_en |-> (used_q[cmt_dst] && used_q[cmt_src] && vld_q[cmt_abs])); // R7
  AST_ALLOC_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && blk_en && (alloc_phys[PHYS_W-1:IPM_W] == sel_mod)) |=> (alloc_nak && !alloc_ok)); // R9
endmodule

// File: rtl/mim_chunk_copier.sv
module mim_chunk_copier #(
  parameter int PHYS_W = 4,
  parameter int SUB_W  = 2,
  parameter int WORD_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [PHYS_W-1:0] src_phys,
  input  logic [PHYS_W-1:0] dst_phys,
  input  logic [SUB_W-1:0]  sub_idx,
  output logic              rd_en,
  output logic [PHYS_W+SUB_W+WORD_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_en,
  output logic [PHYS_W+SUB_W+WORD_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              fin
);
  localparam int ADDR_W = PHYS_W + SUB_W + WORD_W;

  logic              act_q, act_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic              rdv_q, last_q;
  logic [ADDR_W-1:0] wa_q;

  always_comb begin
    act_d  = act_q;
    word_d = word_q;
    if (go) begin
      act_d  = 1'b1;
      word_d = '0;
    end else if (act_q) begin
      if (&word_q) act_d = 1'b0;
      word_d = word_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      word_q <= '0;
      rdv_q  <= 1'b0;
      last_q <= 1'b0;
      wa_q   <= '0;
    end else begin
      act_q  <= act_d;
      word_q <= word_d;
      rdv_q  <= act_q;
      last_q <= act_q && (&word_q);
      if (act_q) wa_q <= {dst_phys, sub_idx, word_q};
    end
  end

  assign rd_en   = act_q;
  assign rd_addr = {src_phys, sub_idx, word_q};
  assign wr_en   = rdv_q;
  assign wr_addr = wa_q;
  assign wr_data = rd_data;
  assign fin     = rdv_q && last_q;

  AST_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (!act_q && !rdv_q)); // R4
endmodule

// File: rtl/mim_engine.sv
module mim_engine #(
  parameter int MOD_W     = 2,
  parameter int IPM_W     = 2,
  parameter int ABS_W     = 4,
  parameter int SUB_W     = 2,
  parameter int WORD_W    = 2,
  parameter int DATA_W    = 16,
  parameter int DELAY_W   = 8,
  parameter int DELAY_MAX = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [MOD_W-1:0]   start_mod,
  input  logic [DELAY_W-1:0] delay_cfg,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic               pause_req,
  input  logic               pause_ack,
  output logic               mem_rd_en,
  output logic [MOD_W+IPM_W+SUB_W+WORD_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0]  mem_rd_data,
  output logic               mem_wr_en,
  output logic [MOD_W+IPM_W+SUB_W+WORD_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0]  mem_wr_data,
  input  logic               alloc_req,
  input  logic [ABS_W-1:0]   alloc_abs,
  input  logic [MOD_W+IPM_W-1:0] alloc_phys,
  output logic               alloc_ok,
  output logic               alloc_nak,
  input  logic [ABS_W-1:0]   lookup_abs,
  output logic               lookup_vld,
  output logic [MOD_W+IPM_W-1:0] lookup_phys
);
  import mim_pkg::*;
  localparam int PHYS_W = MOD_W + IPM_W;
  localparam logic [DELAY_W-1:0] DLY_CAP = DELAY_W'(DELAY_MAX);

  mim_state_e         state_q, state_d;
  logic [MOD_W-1:0]   tgt_q, tgt_d;
  logic               blk_q, blk_d, err_q, err_d, end_q, end_d;
  logic [DELAY_W-1:0] dly_q, dly_d, cnt_q, cnt_d, dly_start;
  logic [SUB_W-1:0]   sub_q, sub_d;
  logic [ABS_W-1:0]   sabs_q, sabs_d;
  logic [PHYS_W-1:0]  sphys_q, sphys_d, dphys_q, dphys_d;
  logic               rsv_en, cmt_en, go, fin;
  logic               src_found, dst_found;
  logic [ABS_W-1:0]   src_abs;
  logic [PHYS_W-1:0]  src_phys, dst_phys;

  assign dly_start = (delay_cfg > DLY_CAP) ? DLY_CAP : delay_cfg;

  mim_remap_table #(.MOD_W(MOD_W), .IPM_W(IPM_W), .ABS_W(ABS_W)) u_table (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_q), .sel_mod(tgt_q),
    .alloc_req(alloc_req), .alloc_abs(alloc_abs), .alloc_phys(alloc_phys),
    .alloc_ok(alloc_ok), .alloc_nak(alloc_nak),
    .rsv_en(rsv_en), .rsv_phys(dst_phys),
    .cmt_en(cmt_en), .cmt_abs(sabs_q), .cmt_src(sphys_q), .cmt_dst(dphys_q),
    .src_found(src_found), .src_abs(src_abs), .src_phys(src_phys),
    .dst_found(dst_found), .dst_phys(dst_phys),
    .lookup_abs(lookup_abs), .lookup_vld(lookup_vld), .lookup_phys(lookup_phys));

  mim_chunk_copier #(.PHYS_W(PHYS_W), .SUB_W(SUB_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_copier (
    .clk(clk), .rst_n(rst_n), .go(go),
    .src_phys(sphys_q), .dst_phys(dphys_q), .sub_idx(sub_q),
    .rd_en(mem_rd_en), .rd_addr(mem_rd_addr), .rd_data(mem_rd_data),
    .wr_en(mem_wr_en), .wr_addr(mem_wr_addr), .wr_data(mem_wr_data), .fin(fin));

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    blk_d   = blk_q;
    err_d   = err_q;
    end_d   = end_q;
    dly_d   = dly_q;
    cnt_d   = cnt_q;
    sub_d   = sub_q;
    sabs_d  = sabs_q;
    sphys_d = sphys_q;
    dphys_d = dphys_q;
    rsv_en  = 1'b0;
    cmt_en  = 1'b0;
    go      = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        tgt_d   = start_mod;
        blk_d   = 1'b1;
        err_d   = 1'b0;
        dly_d   = dly_start;
        state_d = ST_SCAN;
      end
      ST_SCAN: begin
        if (!src_found) state_d = ST_DONE;
        else if (!dst_found) begin
          err_d   = 1'b1;
          state_d = ST_ERR;
        end else begin
          rsv_en  = 1'b1;
          sabs_d  = src_abs;
          sphys_d = src_phys;
          dphys_d = dst_phys;
          sub_d   = '0;
          state_d = ST_PREQ;
        end
      end
      ST_PREQ: if (pause_ack) begin
        go      = 1'b1;
        state_d = ST_COPY;
      end
      ST_COPY: if (fin) state_d = ST_REL;
      ST_REL: if (!pause_ack) begin
        cnt_d = dly_q;
        end_d = &sub_q;
        if (&sub_q) state_d = ST_COMMIT;
        else begin
          sub_d   = sub_q + 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_COMMIT: begin
        cmt_en  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (cnt_q == '0) state_d = end_q ? ST_SCAN : ST_PREQ;
        else cnt_d = cnt_q - 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      ST_ERR:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      blk_q   <= 1'b0;
      err_q   <= 1'b0;
      end_q   <= 1'b0;
      dly_q   <= '0;
      cnt_q   <= '0;
      sub_q   <= '0;
      sabs_q  <= '0;
      sphys_q <= '0;
      dphys_q <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      blk_q   <= blk_d;
      err_q   <= err_d;
      end_q   <= end_d;
      dly_q   <= dly_d;
      cnt_q   <= cnt_d;
      sub_q   <= sub_d;
      sabs_q  <= sabs_d;
      sphys_q <= sphys_d;
      dphys_q <= dphys_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign err       = err_q;
  assign pause_req = (state_q == ST_PREQ) || (state_q == ST_COPY);

  AST_COPY_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en || mem_wr_en) |-> (pause_ack && pause_req)); // R3
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !pause_req); // R8
  AST_DLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (cnt_q <= DLY_CAP)); // R6
endmodule

// File: tb/test_mim_engine.sv
module test_mim_engine;
  localparam int NPH = 16, NAB = 16, WPI = 16, DMAX = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, pause_ack, alloc_req = 1'b0;
  logic [1:0] start_mod = '0;
  logic [7:0] delay_cfg = '0;
  logic [3:0] alloc_abs = '0, alloc_phys = '0, lookup_abs = '0;
  logic busy, done, err, pause_req, mem_rd_en, mem_wr_en, alloc_ok, alloc_nak, lookup_vld;
  logic [7:0] mem_rd_addr, mem_wr_addr;
  logic [15:0] mem_rd_data, mem_wr_data;
  logic [3:0] lookup_phys;

  mim_engine i_mim_engine (.*);

  always #2 clk = ~clk;

  int chk_cnt = 0, fail_cnt = 0, seed = 0, cyc = 0;
  logic [15:0] mem [256];
  bit wseen [256];

  function automatic logic [15:0] pat(int a);
    return 16'(a * 97 + seed * 13 + 1);
  endfunction
  function automatic logic [15:0] memval(int a);
    return wseen[a] ? mem[a] : pat(a);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pause_ack <= 1'b0;
      for (int i = 0; i < 256; i++) wseen[i] <= 1'b0;
    end else begin
      pause_ack <= pause_req;
      if (mem_rd_en) mem_rd_data <= memval(int'(mem_rd_addr));
      if (mem_wr_en) begin
        mem[mem_wr_addr]   <= mem_wr_data;
        wseen[mem_wr_addr] <= 1'b1;
      end
    end
  end

  // port monitor
  logic mon_clr = 1'b0;
  int rises, gap, viol, gaps [64], wins [64], lk [64];
  logic prev_req;
  always @(negedge clk) begin
    if (mon_clr) begin
      rises = 0; gap = 0; viol = 0; prev_req = 1'b0;
    end else begin
      if (pause_req && !prev_req && rises < 64) begin
        gaps[rises] = gap; lk[rises] = int'(lookup_phys); wins[rises] = 0;
        rises++; gap = 0;
      end
      if (!pause_req) gap++;
      if (pause_req && mem_wr_en && rises > 0) wins[rises-1]++;
      if ((mem_rd_en || mem_wr_en) && !pause_ack) viol++;
      prev_req = pause_req;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chk_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fail_cnt++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
      $finish;
    end
  end

  // reference model
  bit used_m [NPH]; bit vld_m [NAB]; int map_m [NAB]; int cont [NPH];
  int mv_abs [16], mv_src [16], mv_dst [16], nmv;

  task automatic do_reset(int s);
    seed = s;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NPH; i++) begin used_m[i] = 0; cont[i] = i; end
    for (int i = 0; i < NAB; i++) begin vld_m[i] = 0; map_m[i] = 0; end
  endtask

  task automatic alloc(int a, int p, bit exp_ok, string req);
    alloc_req = 1'b1; alloc_abs = 4'(a); alloc_phys = 4'(p);
    @(negedge clk);
    alloc_req = 1'b0;
    chk(alloc_ok == exp_ok && alloc_nak == !exp_ok, req, int'(alloc_ok), int'(exp_ok));
    if (exp_ok) begin vld_m[a] = 1; map_m[a] = p; used_m[p] = 1; end
  endtask

  function automatic int free_on(int m);
    for (int p = 0; p < NPH; p++) if (!used_m[p] && p / 4 == m) return p;
    return -1;
  endfunction

  task automatic plan_moves(int t);
    nmv = 0;
    for (int a = 0; a < NAB; a++) begin
      if (vld_m[a] && map_m[a] / 4 == t) begin
        int d = -1;
        for (int p = NPH - 1; p >= 0; p--) if (!used_m[p] && p / 4 != t) d = p;
        used_m[d] = 1; used_m[map_m[a]] = 0; cont[d] = cont[map_m[a]];
        mv_abs[nmv] = a; mv_src[nmv] = map_m[a]; mv_dst[nmv] = d; nmv++;
        map_m[a] = d;
      end
    end
  endtask

  task automatic run_evac(int t, int dcfg);
    int eff = (dcfg > DMAX) ? DMAX : dcfg;
    int tf = free_on(t);
    int w = 0;
    bit saw_done = 0;
    plan_moves(t);
    lookup_abs = (nmv > 0) ? 4'(mv_abs[0]) : 4'd0;
    @(posedge clk); mon_clr = 1'b1; @(posedge clk); mon_clr = 1'b0;
    @(negedge clk);
    start = 1'b1; start_mod = 2'(t); delay_cfg = 8'(dcfg);
    @(negedge clk);
    // busy now: a second start and a target allocation are both refused
    start_mod = 2'((t + 2) % 4); delay_cfg = 8'd0;
    if (tf >= 0) begin alloc_req = 1'b1; alloc_abs = 4'd15; alloc_phys = 4'(tf); end
    @(negedge clk);
    start = 1'b0; alloc_req = 1'b0;
    if (tf >= 0) chk(alloc_nak == 1'b1 && alloc_ok == 1'b0, "R9 target alloc refused while busy", int'(alloc_ok), 0);
    while (!done && !err && w < 20000) begin @(negedge clk); w++; end
    saw_done = done;
    chk(saw_done && !err, "R10 done pulse", int'(saw_done), 1);
    @(negedge clk);
    chk(!busy && !done, "R10 idle after done", int'(busy), 0);
    chk(rises == nmv * 4, "R4 chunk count", rises, nmv * 4);
    chk(viol == 0, "R3 traffic outside pause", viol, 0);
    for (int r = 0; r < rises && r < 64; r++) begin
      chk(wins[r] == 4, "R4 words per chunk", wins[r], 4);
      if (r > 0) begin
        int eg = (r % 4 == 0) ? eff + 5 : eff + 3;
        chk(gaps[r] == eg, "R5 R6 idle gap", gaps[r], eg);
      end
      if (r < 4) chk(lk[r] == mv_src[0], "R7 lookup stays on source during copy", lk[r], mv_src[0]);
    end
    for (int a = 0; a < NAB; a++) begin
      if (vld_m[a]) begin
        bit same = 1;
        lookup_abs = 4'(a);
        #1;
        chk(lookup_vld && int'(lookup_phys) == map_m[a], "R2 R7 final mapping", int'(lookup_phys), map_m[a]);
        for (int k = 0; k < WPI; k++)
          if (memval(map_m[a] * WPI + k) != pat(cont[map_m[a]] * WPI + k)) same = 0;
        chk(same, "R4 data intact", int'(same), 1);
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    do_reset(1);
    chk(!busy && !pause_req && !err && !done, "R11 idle after reset", int'(busy), 0);
    for (int a = 0; a < NAB; a++) begin
      lookup_abs = 4'(a); #1;
      chk(!lookup_vld, "R11 lookup invalid after reset", int'(lookup_vld), 0);
    end
    for (int t = 0; t < 4; t++) begin
      int dl [4] = '{0, 1, 5, 200};
      int tb2;
      do_reset(t + 2);
      for (int k = 0; k < 10; k++) alloc(k, (k * 5 + t * 3) % 16, 1'b1, "R1 alloc accepted");
      alloc(12, map_m[0], 1'b0, "R1 used physical refused");
      alloc(0, free_on((t + 1) % 4), 1'b0, "R1 mapped absolute refused");
      run_evac(t, dl[t]);
      tb2 = free_on(t);
      if (tb2 >= 0) alloc(14, tb2, 1'b0, "R9 target still blocked after done");
      run_evac((t + 1) % 4, dl[(t + 1) % 4]);
      tb2 = free_on(t);
      if (tb2 >= 0) alloc(15, tb2, 1'b1, "R7 R9 freed source allocatable after new start");
    end
    // no destination left
    do_reset(9);
    begin
      int k = 0;
      for (int p = 0; p < NPH; p++) if (p / 4 != 1) begin alloc(k, p, 1'b1, "R1 fill"); k++; end
      alloc(12, 4, 1'b1, "R1 fill target");
    end
    lookup_abs = 4'd12;
    @(posedge clk); mon_clr = 1'b1; @(posedge clk); mon_clr = 1'b0;
    @(negedge clk); start = 1'b1; start_mod = 2'd1; delay_cfg = 8'd3;
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk(err == 1'b1, "R8 error raised", int'(err), 1);
    chk(!busy, "R8 busy dropped", int'(busy), 0);
    chk(rises == 0, "R8 no pause requested", rises, 0);
    chk(lookup_vld && lookup_phys == 4'd4, "R8 mapping unchanged", int'(lookup_phys), 4);
    $display("TB_RESULT checks=%0d failures=%0d", chk_cnt, fail_cnt);
    $finish;
  end
endmodule